// File: doc/BRIEF.md
# SAR ADC conversion sequencer

This block is the digital control for a 16-bit charge-redistribution successive-approximation converter. While idle it holds the capacitor array in acquisition. The common-node and dummy sampling switches are closed, and the array is connected to the analog inputs. A falling edge on the active-low convert-start input begins a conversion. The sampling switches open first. One cycle later the array is moved off the inputs onto reference ground, and a binary search runs from the MSB down to the LSB. Each trial bit is driven to the reference. The bit is kept or dropped according to a single comparator bit.

When the LSB has been decided, the 16-bit code for the sample just taken appears on the data output. BUSY drops on the same clock edge, and the switches return to acquisition. A mode input selects the fast, normal or low-power timing, which sets how many clock cycles each bit trial settles.

An idle timer flags results in the fast mode that may be inaccurate. Such a result follows a gap longer than a parameterised cycle limit since the previous conversion start, or is the first conversion after reset.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy_o is 0, data_o is 0 and stale_o is 0. The outputs are in acquisition: sw_a_o=1, sw_b_o=1, in_sel_o=1 and bit_ref_o=0.
- R2: The design samples cnvst_ni low on a clock edge, having sampled it high on the previous edge, while not busy. busy_o is 1 after that same edge. A low level held through reset does not start a conversion.
- R3: While busy_o is 1, any change on cnvst_ni has no effect. The conversion length and the result stay unchanged.
- R4: In the first busy cycle sw_a_o and sw_b_o are 0 (open) while in_sel_o is still 1 (inputs connected). In the next cycle in_sel_o is 0 (reference ground) and bit_ref_o is 16'h8000.
- R5: The search runs MSB first. A trial bit is set in bit_ref_o (1 = reference). If comp_i is 1 at the end of the bit's settle window, the bit is cleared; otherwise it is kept. With comp_i = (bit_ref_o > v), data_o equals v.
- R6: mode_i is sampled at the start edge and gives a settle count S per bit: 0 is fast (S=1), 1 is normal (S=2), 2 is low-power (S=3), and 3 behaves as normal. busy_o stays 1 for exactly 1+16*S cycles.
- R7: On the edge that decides the LSB, data_o is updated and busy_o goes to 0. The outputs return to acquisition: sw_a_o=1, sw_b_o=1, in_sel_o=1 and bit_ref_o=0.
- R8: In mode 0, stale_o is 1 along with the result in two cases. The first case is a conversion whose start edge came more than IDLE_LIMIT cycles after the previous start edge. The second is the first conversion after reset. Otherwise stale_o is 0.
- R9: In modes 1, 2 and 3, stale_o is 0 with every result, whatever the idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnvst_ni | input | 1 | Convert start, active low, edge triggered |
| comp_i | input | 1 | Comparator; 1 = trial overshoots |
| mode_i | input | 2 | Timing mode: 0 fast, 1 normal, 2 low-power, 3 normal |
| sw_a_o | output | 1 | Common-node sampling switch, 1 = closed |
| sw_b_o | output | 1 | Dummy sampling switch, 1 = closed |
| in_sel_o | output | 1 | Array and dummy source, 1 = analog inputs, 0 = reference ground |
| bit_ref_o | output | 16 | Per-bit select, 1 = reference, 0 = reference ground |
| busy_o | output | 1 | Conversion in progress |
| data_o | output | 16 | Last conversion result |
| stale_o | output | 1 | Last result follows a long idle gap in fast mode |

## Verification
Every cycle, the assertions check the following. The sampling switches are already open when the array leaves the inputs, and both switches stay open while busy. At most one trial bit is active at a time. BUSY drops right after the final decision. BUSY rises only after a sampled low on convert-start, and the idle counter never passes its limit. Only the bench scenarios can show the rest: that the code equals the modelled analog value, that the busy length matches each mode's settle count, that a convert-start glitch mid-conversion changes nothing, and that the stale flag flips exactly at one cycle beyond the idle limit.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    MODE_FAST   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_LOWPWR = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_ACQ   = 2'd0,
    ST_OPEN  = 2'd1,
    ST_TRIAL = 2'd2
  } state_e;
endpackage

// File: rtl/sar_start_det.sv
module sar_start_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnvst_ni,
  input  logic idle_i,
  output logic start_o
);
  logic prev_q;

  // reset to low so a level held through reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cnvst_ni;
  end

  assign start_o = prev_q & ~cnvst_ni & idle_i;
endmodule

// File: rtl/sar_idle_timer.sv
module sar_idle_timer #(
  parameter int IDLE_LIMIT = 250000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  sar_seq_pkg::mode_e    mode_i,
  input  logic                  done_i,
  output logic                  stale_o
);
  import sar_seq_pkg::*;

  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          stale_q;

  // counter starts saturated so the first conversion after reset is flagged
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= LIM;
      pend_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      pend_q <= (mode_i == MODE_FAST) && (cnt_q == LIM);
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stale_q <= 1'b0;
    else if (done_i) stale_q <= pend_q;
  end

  assign stale_o = stale_q;

  // R8
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
endmodule

// File: rtl/sar_bit_search.sv
module sar_bit_search #(
  parameter int NBITS       = 16,
  parameter int FAST_SETTLE = 1,
  parameter int NORM_SETTLE = 2,
  parameter int LOW_SETTLE  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  sar_seq_pkg::mode_e mode_i,
  input  logic               comp_i,
  output logic               sw_a_o,
  output logic               sw_b_o,
  output logic               in_sel_o,
  output logic [NBITS-1:0]   bit_ref_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [NBITS-1:0]   data_o
);
  import sar_seq_pkg::*;

  localparam int MAX_A  = (FAST_SETTLE > NORM_SETTLE) ? FAST_SETTLE : NORM_SETTLE;
  localparam int MAX_S  = (MAX_A > LOW_SETTLE) ? MAX_A : LOW_SETTLE;
  localparam int CNT_W  = (MAX_S < 2) ? 1 : $clog2(MAX_S);

  state_e             state_q;
  mode_e              mode_q;
  logic [NBITS-1:0]   code_q;
  logic [NBITS-1:0]   mask_q;
  logic [NBITS-1:0]   data_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   last_cnt;
  logic               decide;
  logic [NBITS-1:0]   code_next;

  always_comb begin
    case (mode_q)
      MODE_FAST:   last_cnt = CNT_W'(FAST_SETTLE - 1);
      MODE_LOWPWR: last_cnt = CNT_W'(LOW_SETTLE - 1);
      default:     last_cnt = CNT_W'(NORM_SETTLE - 1);
    endcase
  end

  assign decide    = (state_q == ST_TRIAL) && (cnt_q == last_cnt);
  // comparator 1 = overshoot, trial bit dropped
  assign code_next = comp_i ? code_q : (code_q | mask_q);
  assign done_o    = decide && mask_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACQ;
      mode_q  <= MODE_FAST;
      code_q  <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        ST_ACQ: if (start_i) begin
          state_q <= ST_OPEN;
          mode_q  <= mode_i;
          code_q  <= '0;
          mask_q  <= '0;
          cnt_q   <= '0;
        end
        ST_OPEN: begin
          state_q <= ST_TRIAL;
          mask_q  <= {1'b1, {(NBITS-1){1'b0}}};
          cnt_q   <= '0;
        end
        ST_TRIAL: begin
          if (decide) begin
            cnt_q <= '0;
            if (mask_q[0]) begin
              data_q  <= code_next;
              state_q <= ST_ACQ;
              code_q  <= '0;
              mask_q  <= '0;
            end else begin
              code_q <= code_next;
              mask_q <= mask_q >> 1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_ACQ;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_ACQ);
  assign sw_a_o   = (state_q == ST_ACQ);
  assign sw_b_o   = (state_q == ST_ACQ);
  assign in_sel_o = (state_q != ST_TRIAL);
  assign data_o   = data_q;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit_sw
    assign bit_ref_o[i] = (state_q == ST_TRIAL) && (code_q[i] | mask_q[i]);
  end

  // R4
  sw_before_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_sel_o) |-> ($past(!sw_a_o) && $past(!sw_b_o)));

  // R4
  busy_sw_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!sw_a_o && !sw_b_o));

  // R5
  one_trial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_q));

  // R7
  done_drop_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && sw_a_o && in_sel_o));
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS       = 16,
  parameter int IDLE_LIMIT  = 250000,
  parameter int FAST_SETTLE = 1,
  parameter int NORM_SETTLE = 2,
  parameter int LOW_SETTLE  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnvst_ni,
  input  logic             comp_i,
  input  logic [1:0]       mode_i,
  output logic             sw_a_o,
  output logic             sw_b_o,
  output logic             in_sel_o,
  output logic [NBITS-1:0] bit_ref_o,
  output logic             busy_o,
  output logic [NBITS-1:0] data_o,
  output logic             stale_o
);
  import sar_seq_pkg::*;

  logic  start;
  logic  done;
  mode_e mode;

  assign mode = mode_e'(mode_i);

  sar_start_det i_start_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnvst_ni (cnvst_ni),
    .idle_i   (!busy_o),
    .start_o  (start)
  );

  sar_bit_search #(
    .NBITS       (NBITS),
    .FAST_SETTLE (FAST_SETTLE),
    .NORM_SETTLE (NORM_SETTLE),
    .LOW_SETTLE  (LOW_SETTLE)
  ) i_bit_search (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .mode_i    (mode),
    .comp_i    (comp_i),
    .sw_a_o    (sw_a_o),
    .sw_b_o    (sw_b_o),
    .in_sel_o  (in_sel_o),
    .bit_ref_o (bit_ref_o),
    .busy_o    (busy_o),
    .done_o    (done),
    .data_o    (data_o)
  );

  sar_idle_timer #(
    .IDLE_LIMIT (IDLE_LIMIT)
  ) i_idle_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .mode_i  (mode),
    .done_i  (done),
    .stale_o (stale_o)
  );

  // R2
  busy_needs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(!cnvst_ni));
endmodule

// File: tb/test_sar_seq.sv
module test_sar_seq;
  localparam int LIMIT = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnvst_n;
  logic        comp;
  logic [1:0]  mode;
  logic        sw_a, sw_b, in_sel, busy, stale;
  logic [15:0] bit_ref, data_out, vin;

  always #2 clk = ~clk;

  assign comp = (bit_ref > vin);

  sar_seq #(.IDLE_LIMIT(LIMIT)) i_sar_seq (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cnvst_ni  (cnvst_n),
    .comp_i    (comp),
    .mode_i    (mode),
    .sw_a_o    (sw_a),
    .sw_b_o    (sw_b),
    .in_sel_o  (in_sel),
    .bit_ref_o (bit_ref),
    .busy_o    (busy),
    .data_o    (data_out),
    .stale_o   (stale)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int prev_start = 0;
  bit first = 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int settle_of(input logic [1:0] m);
    case (m)
      2'd0:    return 1;
      2'd2:    return 3;
      default: return 2;
    endcase
  endfunction

  function automatic bit exp_stale(input logic [1:0] m, input bit fst, input int gap);
    return (m == 2'd0) && (fst || gap > LIMIT);
  endfunction

  task automatic convert(input logic [15:0] v, input logic [1:0] m, input int gap,
                         input bit glitch);
    int s;
    int len;
    int target;
    bit es;
    s = settle_of(m);
    target = prev_start + gap;
    @(negedge clk);
    vin  = v;
    mode = m;
    if (!first) while (cyc < target - 1) @(negedge clk);
    cnvst_n = 1'b0;
    @(posedge clk); #1;
    es = exp_stale(m, first, cyc - prev_start);
    prev_start = cyc;
    first = 1'b0;
    check(busy == 1'b1, "R2 busy rise", busy, 1);
    check({sw_a, sw_b, in_sel} == 3'b001, "R4 switches open first",
          {sw_a, sw_b, in_sel}, 3'b001);
    @(posedge clk); #1;
    check(in_sel == 1'b0 && bit_ref == 16'h8000, "R4 MSB trial",
          {in_sel, bit_ref}, 17'h08000);
    len = 2;
    while (busy && len < 200) begin
      if (glitch && len == 5) cnvst_n = 1'b1;
      if (glitch && len == 7) cnvst_n = 1'b0;
      @(posedge clk); #1;
      if (busy) len++;
    end
    check(len == 1 + 16 * s, glitch ? "R3 length" : "R6 length", len, 1 + 16 * s);
    check(data_out == v, glitch ? "R3 result" : "R5 result", data_out, v);
    check(stale == es, (m == 2'd0) ? "R8 stale" : "R9 stale", stale, es);
    check({sw_a, sw_b, in_sel} == 3'b111 && bit_ref == 16'h0, "R7 acquisition",
          {sw_a, sw_b, in_sel, bit_ref}, 19'h70000);
    @(negedge clk);
    cnvst_n = 1'b1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n   = 1'b0;
    cnvst_n = 1'b0;
    mode    = 2'd0;
    vin     = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(busy == 1'b0 && data_out == 16'h0 && stale == 1'b0, "R1 reset outputs",
          {busy, stale, data_out}, 0);
    check({sw_a, sw_b, in_sel} == 3'b111 && bit_ref == 16'h0, "R1 reset switches",
          {sw_a, sw_b, in_sel, bit_ref}, 19'h70000);
    // low held through reset must not start
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R2 no start from held low", busy, 0);
    cnvst_n = 1'b1;
    repeat (2) @(negedge clk);

    convert(16'h0000, 2'd0, 0, 1'b0);
    convert(16'hFFFF, 2'd0, 40, 1'b0);
    convert(16'h8000, 2'd1, 60, 1'b0);
    convert(16'h7FFF, 2'd2, 60, 1'b0);
    convert(16'h0001, 2'd3, 60, 1'b0);
    convert(16'hA5A5, 2'd0, LIMIT, 1'b0);
    convert(16'h5A5A, 2'd0, LIMIT + 1, 1'b0);
    convert(16'h1234, 2'd1, 300, 1'b0);
    convert(16'h4321, 2'd2, 400, 1'b0);
    convert(16'hC001, 2'd0, 30, 1'b1);
    convert(16'h3FFE, 2'd2, 70, 1'b1);

    for (int k = 0; k < 40; k++) begin
      logic [1:0]  rm;
      logic [15:0] rv;
      int          rg;
      rm = 2'($urandom_range(0, 3));
      rv = 16'($urandom);
      rg = 56 + $urandom_range(0, 260);
      convert(rv, rm, rg, ($urandom_range(0, 3) == 0));
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule